// File: doc/BRIEF.md
# Dual Gated Timer/Counter

Two independent 8+8-bit counting channels that count either a free-running machine-cycle tick or falling edges seen on an external count pin. Each channel has its own gate pin that can hold the count off. A rollover raises a sticky flag that software can clear, and it also produces a one-clock pulse that other logic can use as a rate tick. Each channel can be set to one of four widths or arrangements: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, or a split arrangement in which channel 0 becomes two independent 8-bit counters.

Software configures the block through a flat register port. A write strobe carries a 3-bit address and a byte. Read data comes back combinationally for any address. The machine-cycle tick is made inside the block by dividing the clock by a parameter.

Top module: `timer_pair`

## Requirements
- R1: After reset every register reads 0 and both pulse outputs are low. Register map: address 0 is the control byte, with bit0 run0, bit1 flag0, bit2 run1 and bit3 flag1. Address 1 is the mode byte, with [1:0] mode0, bit2 external-count select 0, bit3 gate0, [5:4] mode1, bit6 external-count select 1 and bit7 gate1. Addresses 2, 3, 4 and 5 are low0, high0, low1 and high1. Addresses 6 and 7 read 0.
- R2: With external-count select 0, a running channel advances by one on each machine tick. The machine tick occurs once every MC_DIV clocks.
- R3: A channel advances only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise its count holds.
- R4: With external-count select 1, the count pin is sampled on each machine tick. The count advances once for each sampled 1-to-0 transition. Steady levels and rising transitions do not advance it.
- R5: Mode 0 counts 13 bits formed by high (upper 8 bits) above low[4:0]. low[7:5] keep their written value. Rolling over from all ones sets the flag.
- R6: Mode 1 counts 16 bits {high, low}. Rolling over from FFFFh to 0000h sets the flag.
- R7: Mode 2 counts in low only. When low overflows, it is reloaded from high, high is unchanged, and the flag is set.
- R8: In mode 3, channel 0's low byte counts under channel 0's run, gate and select and sets flag0. Channel 0's high byte counts machine ticks whenever run1 is 1 and sets flag1 on rollover. Channel 1 in mode 3 holds its count.
- R9: A control-byte write loads both flags from the written bits. A hardware flag set in the same clock wins over a written 0.
- R10: ovf_pulse[i] is high for exactly one clock after each rollover of channel i's own counter, in the same clock its flag becomes 1. The high byte of channel 0 in mode 3 does not drive a pulse.
- R11: A register write to a count byte in the same clock as an increment leaves the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read byte (combinational) |
| ext_cnt | input | 2 | External count pins, one per channel |
| ext_gate | input | 2 | Gate pins, one per channel |
| ovf_pulse | output | 2 | One-clock rollover pulses, one per channel |

## Verification
The main instance is built with MC_DIV=1, so every clock is a machine tick. Full 256-step rollovers, exact gate windows and same-clock write/overflow collisions can therefore be placed on precise edges. A second instance, built with MC_DIV=4, receives the same stimulus; it shows that a 40-clock gate window yields exactly ten increments whatever the divider phase. The edge detector is driven with held levels of both polarities, so that it can be shown to count only falling transitions.

// File: rtl/timer_pair.sv
module timer_pair #(
  parameter int MC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [1:0] ext_cnt,
  input  logic [1:0] ext_gate,
  output logic [1:0] ovf_pulse
);
  localparam int DIVW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;

  logic tick;
  generate
    if (MC_DIV > 1) begin : g_div
      logic [DIVW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) div_q <= '0;
        else if (div_q == DIVW'(MC_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      assign tick = (div_q == DIVW'(MC_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  logic [7:0] tl0, th0, tl1, th1, mode_q;
  logic [1:0] run_q, flag_q, smp_q, ovf_q;

  wire [1:0] m0 = mode_q[1:0];
  wire       ct0 = mode_q[2];
  wire       gt0 = mode_q[3];
  wire [1:0] m1 = mode_q[5:4];
  wire       ct1 = mode_q[6];
  wire       gt1 = mode_q[7];

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] l, input logic [7:0] h);
    logic [13:0] c13;
    logic [16:0] r;
    c13 = {1'b0, h, l[4:0]} + 14'd1;
    case (m)
      2'd0: r = {c13[13], c13[12:5], l[7:5], c13[4:0]};
      2'd1: r = {1'b0, h, l} + 17'd1;
      2'd2: r = (l == 8'hFF) ? {1'b1, h, h} : {1'b0, h, l + 8'd1};
      default: r = {l == 8'hFF, h, l + 8'd1};
    endcase
    return r;
  endfunction

  wire ev0 = tick & (ct0 ? (smp_q[0] & ~ext_cnt[0]) : 1'b1);
  wire ev1 = tick & (ct1 ? (smp_q[1] & ~ext_cnt[1]) : 1'b1);
  wire en0 = run_q[0] & (~gt0 | ext_gate[0]);
  wire en1 = run_q[1] & (~gt1 | ext_gate[1]);

  wire inc0  = en0 & ev0;
  wire inc1  = en1 & ev1 & (m1 != 2'd3);
  wire split = (m0 == 2'd3);
  wire inc_h = split & run_q[1] & tick;

  wire [16:0] nx0 = step(m0, tl0, th0);
  wire [16:0] nx1 = step(m1, tl1, th1);

  wire ov0  = inc0 & nx0[16];
  wire ov1  = inc1 & nx1[16];
  wire ovh  = inc_h & (th0 == 8'hFF);
  wire set0 = ov0;
  wire set1 = split ? ovh : ov1;

  wire wctl = wr_en & (wr_addr == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl0 <= '0; th0 <= '0; tl1 <= '0; th1 <= '0;
      mode_q <= '0; run_q <= '0; flag_q <= '0; smp_q <= '0; ovf_q <= '0;
    end else begin
      if (tick) smp_q <= ext_cnt;
      ovf_q <= {ov1, ov0};

      if (wctl) run_q <= {wr_data[2], wr_data[0]};
      if (wr_en && wr_addr == 3'd1) mode_q <= wr_data;

      if (set0) flag_q[0] <= 1'b1;
      else if (wctl) flag_q[0] <= wr_data[1];
      if (set1) flag_q[1] <= 1'b1;
      else if (wctl) flag_q[1] <= wr_data[3];

      if (wr_en && wr_addr == 3'd2) tl0 <= wr_data;
      else if (inc0) tl0 <= nx0[7:0];

      if (wr_en && wr_addr == 3'd3) th0 <= wr_data;
      else if (split) begin
        if (inc_h) th0 <= th0 + 8'd1;
      end else if (inc0) th0 <= nx0[15:8];

      if (wr_en && wr_addr == 3'd4) tl1 <= wr_data;
      else if (inc1) tl1 <= nx1[7:0];

      if (wr_en && wr_addr == 3'd5) th1 <= wr_data;
      else if (inc1) th1 <= nx1[15:8];
    end
  end

  always_comb
    case (rd_addr)
      3'd0: rd_data = {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
      3'd1: rd_data = mode_q;
      3'd2: rd_data = tl0;
      3'd3: rd_data = th0;
      3'd4: rd_data = tl1;
      3'd5: rd_data = th1;
      default: rd_data = 8'h00;
    endcase

  assign ovf_pulse = ovf_q;

  // R10: a channel-0 pulse always coincides with its flag
  a_r10_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |-> flag_q[0]);

  // R3: a stopped channel-0 low byte stays put unless written
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !(wr_en && wr_addr == 3'd2)) |=> $stable(tl0));

  // R7: after a reload overflow the low byte equals the high byte
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 == 2'd2 && ovf_pulse[0] && !$past(wr_en)) |-> (tl0 == th0));

  // R9: flag0 rises only from a rollover or a software write of 1
  a_r9_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> (ovf_pulse[0] || $past(wctl && wr_data[1])));

  // R8: channel 1 in mode 3 holds its count
  a_r8_t1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 == 2'd3 && !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5))) |=> ($stable(tl1) && $stable(th1)));
endmodule

// File: tb/timer_pair_test.sv
module timer_pair_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] ext_cnt = 0, ext_gate = 0;
  logic [7:0] rd_data, rd_data_s;
  logic [1:0] ovf_pulse, ovf_pulse_s;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  timer_pair #(.MC_DIV(1)) uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data(rd_data), .ext_cnt, .ext_gate, .ovf_pulse(ovf_pulse));
  timer_pair #(.MC_DIV(4)) uut_slow (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data(rd_data_s), .ext_cnt, .ext_gate, .ovf_pulse(ovf_pulse_s));

  // {mode, tl, th, edges, exp_tl, exp_th, exp_flag}
  localparam logic [63:0] VEC [10] = '{
    {8'd1, 8'h00, 8'h00, 16'd5,   8'h05, 8'h00, 8'd0},  // R6
    {8'd1, 8'hFE, 8'h00, 16'd3,   8'h01, 8'h01, 8'd0},  // R6
    {8'd1, 8'hFE, 8'hFF, 16'd3,   8'h01, 8'h00, 8'd1},  // R6
    {8'd0, 8'hFE, 8'h00, 16'd3,   8'hE1, 8'h01, 8'd0},  // R5
    {8'd0, 8'h1F, 8'hFF, 16'd1,   8'h00, 8'h00, 8'd1},  // R5
    {8'd0, 8'hA5, 8'h07, 16'd4,   8'hA9, 8'h07, 8'd0},  // R5
    {8'd2, 8'hFD, 8'h80, 16'd4,   8'h81, 8'h80, 8'd1},  // R7
    {8'd2, 8'h10, 8'hF0, 16'd2,   8'h12, 8'hF0, 8'd0},  // R7
    {8'd3, 8'hFF, 8'h33, 16'd2,   8'h01, 8'h33, 8'd1},  // R8
    {8'd1, 8'h00, 8'hFF, 16'd256, 8'h00, 8'h00, 8'd1}   // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic gate0(input int n);
    @(negedge clk); ext_gate[0] = 1;
    repeat (n) @(negedge clk);
    ext_gate[0] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1", d, 8'h00); end
    chk("R1", {6'b0, ovf_pulse}, 8'h00);

    // vector table: timer function, gated windows on channel 0
    for (int i = 0; i < 10; i++) begin
      wr(3'd1, 8'h08 | {6'b0, VEC[i][57:56]});
      wr(3'd0, 8'h01);
      wr(3'd2, VEC[i][55:48]);
      wr(3'd3, VEC[i][47:40]);
      gate0(int'(VEC[i][39:24]));
      rd(3'd2, d); chk("R5/R6/R7/R8 low", d, VEC[i][23:16]);
      rd(3'd3, d); chk("R5/R6/R7/R8 high", d, VEC[i][15:8]);
      rd(3'd0, d); chk("R9 flag0", {7'b0, d[1]}, {7'b0, VEC[i][0]});
    end

    // R2: prescaled tick
    wr(3'd1, 8'h09); wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate0(40);
    rd(3'd2, d); chk("R2 div1", d, 8'h28);
    chk("R2 div4", rd_data_s, 8'h0A);

    // R4: falling edges on channel 1 count pin
    ext_cnt[1] = 1;
    wr(3'd1, 8'h58); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd0, 8'h04);
    repeat (3) @(negedge clk); ext_cnt[1] = 0;
    repeat (3) @(negedge clk); ext_cnt[1] = 1;
    repeat (3) @(negedge clk); ext_cnt[1] = 0;
    repeat (3) @(negedge clk); ext_cnt[1] = 1;
    repeat (2) @(negedge clk); ext_cnt[1] = 0;
    repeat (2) @(negedge clk); ext_cnt[1] = 1;
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R4", d, 8'h03);
    rd(3'd5, d); chk("R4", d, 8'h00);

    // R3: run off, then gated off
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'h77);
    repeat (10) @(negedge clk);
    rd(3'd2, d); chk("R3 run", d, 8'h77);
    wr(3'd1, 8'h09); wr(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    rd(3'd2, d); chk("R3 gate", d, 8'h77);

    // R11: write beats increment
    wr(3'd1, 8'h01); wr(3'd0, 8'h01); wr(3'd2, 8'h40);
    rd(3'd2, d); chk("R11", d, 8'h40);
    wr(3'd0, 8'h00);

    // R10: single pulse on rollover
    wr(3'd1, 8'h09); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); ext_gate[0] = 1;
    @(negedge clk); ext_gate[0] = 0;
    #1 chk("R10 high", {6'b0, ovf_pulse}, 8'h01);
    rd(3'd0, d); chk("R10 flag", d, 8'h03);
    @(negedge clk); #1 chk("R10 low", {6'b0, ovf_pulse}, 8'h00);

    // R8 split mode, R9 hardware set beats clear
    wr(3'd0, 8'h00); wr(3'd1, 8'h33);
    wr(3'd2, 8'h00); wr(3'd3, 8'hFE); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 8'h04;
    @(negedge clk); wr_en = 0;
    @(negedge clk); wr_en = 1; wr_data = 8'h00;
    @(negedge clk); wr_en = 0;
    rd(3'd3, d); chk("R8 high0", d, 8'h00);
    rd(3'd2, d); chk("R8 low0", d, 8'h00);
    rd(3'd4, d); chk("R8 low1", d, 8'h55);
    rd(3'd5, d); chk("R8 high1", d, 8'h66);
    rd(3'd0, d); chk("R9 priority", d, 8'h08);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R9 clear", d, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule